// File: doc/BRIEF.md
# Interrupt-Triggered DMA Channel Dispatcher

This block sits between the interrupt sources and the CPU interrupt path and decides, for each accepted interrupt request, whether it is served by a DMA channel or passed on to the CPU. Every channel owns a programmable start-vector register and a 16-bit transfer counter. When the vector of an accepted request equals a channel's start vector, the request is not forwarded. Instead the block issues one transfer request on that channel, waits for the acknowledge, and decrements that channel's counter.

When a channel's counter reaches zero, the block emits a one-cycle end-of-transfer pulse for that channel and clears the channel's start vector, which disarms it. If several channels hold the same vector, the lowest-numbered armed one is served first. Once it disarms, further requests with that vector fall through to the next higher channel that holds it. Software can keep the lower channel in front by rewriting its vector in response to the end pulse. A write-only clear register turns a written vector value into a one-cycle flag-clear command for the interrupt controller.

The control path is a three-state machine. In `S_IDLE` a request is accepted. If a channel matches, the machine takes transition IDLE->XFER; otherwise the request is forwarded and the machine stays in IDLE. In `S_XFER` the transfer request is held until the acknowledge arrives, then the machine takes XFER->CHECK. In `S_CHECK` the decremented counter is examined, the end pulse and disarm are raised if it is zero, and the machine always takes CHECK->IDLE.

Top module: `irq_dma_dispatch`

## Requirements
- R1: An accepted request whose vector equals a nonzero channel start vector is not forwarded to the CPU (`cpu_irq_valid` low). From the next cycle on, `xfer_req` is high with `xfer_chan` set to that channel.
- R2: An accepted request that matches no channel is forwarded in the same cycle: `cpu_irq_valid` is high and `cpu_irq_vector` equals the request vector. A start vector of 0 never matches, and a request with vector 0 is always forwarded.
- R3: When several channels hold the requested vector, the lowest-numbered one is served.
- R4: Each cycle in which `xfer_ack` is high while `xfer_req` is high decrements the served channel's counter by exactly one. A software counter write in the same cycle takes precedence. A loaded count of 0 wraps, which gives 65536 transfers.
- R5: If the decremented counter is zero, `eot` carries a one-hot pulse for that channel in the cycle after the acknowledge. The pulse lasts exactly one cycle. Otherwise `eot` stays zero.
- R6: At the zero count the channel's start vector is cleared. Later requests with that vector go to the next higher channel holding it, or to the CPU if no channel holds it.
- R7: Rewriting a disarmed channel's start vector re-arms it, and it then takes priority over higher channels with the same vector again.
- R8: A write to address 0xF8 produces, in the following cycle, a one-cycle `clr_valid` pulse with `clr_vector` equal to the written byte. Reading 0xF8 returns 0.
- R9: After reset, all start vectors and counters read 0, and `clr_valid`, `clr_vector`, `eot` and `xfer_req` are 0. `irq_ready` is 1.
- R10: Only one request is in service at a time. `irq_ready` is low from acceptance until the machine is idle again. `xfer_req` and `xfer_chan` stay stable until acknowledged.
- R11: Register map (byte wide): the start vector of channel n is at 0x00+n, the counter low byte at 0x10+2n, and the counter high byte at 0x11+2n. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| irq_valid | input | 1 | Interrupt request present |
| irq_vector | input | 8 | Vector of the pending interrupt |
| irq_ready | output | 1 | Request accepted this cycle when high with irq_valid |
| cpu_irq_valid | output | 1 | Request forwarded to the CPU |
| cpu_irq_vector | output | 8 | Vector of the forwarded request |
| xfer_req | output | 1 | Transfer request to the bus mover |
| xfer_chan | output | 3 | Channel of the transfer request |
| xfer_ack | input | 1 | Transfer done acknowledge |
| eot | output | 8 | One-hot end-of-transfer pulses, one bit per channel |
| clr_valid | output | 1 | Flag-clear command pulse |
| clr_vector | output | 8 | Vector whose request flag is to be cleared |

## Verification
If the start vector of a channel is held wrongly, the fault shows at the ports in the very cycle of the next request with that vector: `cpu_irq_valid` comes up where it should stay low, or the reverse. A faulty priority pick shows one cycle later, as a wrong `xfer_chan`. If a counter is off by one, `eot` fires one transfer early or late, in the cycle after the acknowledge. A disarm that fails to happen stays hidden until the next request with that vector, which is then routed to the exhausted channel instead of the next higher one. The directed scenarios therefore always follow an expiry with one more request and a register read-back.

// File: rtl/idd_pkg.sv
package idd_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_XFER  = 2'd1,
        S_CHECK = 2'd2
    } idd_state_e;
endpackage

// File: rtl/idd_chan_regs.sv
// One channel: start-vector register and transfer counter.
module idd_chan_regs #(
    parameter int DW = 8,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vec_we,
    input  logic          cnt_lo_we,
    input  logic          cnt_hi_we,
    input  logic [DW-1:0] wdata,
    input  logic          dec,
    input  logic          expire,
    output logic [DW-1:0] vec,
    output logic [CW-1:0] cnt
);
    // Software write beats the automatic disarm.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vec <= '0;
        else if (vec_we)  vec <= wdata;
        else if (expire)  vec <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_lo_we || cnt_hi_we) begin
            if (cnt_lo_we) cnt[DW-1:0]  <= wdata;
            if (cnt_hi_we) cnt[CW-1:DW] <= wdata;
        end else if (dec) begin
            cnt <= cnt - CW'(1);
        end
    end

    assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !vec_we |=> vec == '0);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !cnt_lo_we && !cnt_hi_we |=> cnt == $past(cnt) - CW'(1));
endmodule

// File: rtl/idd_vec_match.sv
// Compares the request vector with every armed channel; lowest index wins.
module idd_vec_match #(
    parameter int NCH = 8,
    parameter int DW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0][DW-1:0] vecs,
    input  logic [DW-1:0]          req_vec,
    output logic                   hit,
    output logic [CHW-1:0]         chan
);
    logic [NCH-1:0] match;

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign match[g] = (vecs[g] != '0) && (vecs[g] == req_vec);
    end

    always_comb begin
        hit  = |match;
        chan = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (match[i]) chan = CHW'(i);
        end
    end
endmodule

// File: rtl/irq_dma_dispatch.sv
module irq_dma_dispatch
    import idd_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int AW  = 8,
    parameter logic [AW-1:0] VEC_BASE = 8'h00,
    parameter logic [AW-1:0] CNT_BASE = 8'h10,
    parameter logic [AW-1:0] CLR_ADDR = 8'hF8,
    localparam int CW  = 2 * DW,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           irq_valid,
    input  logic [DW-1:0]  irq_vector,
    output logic           irq_ready,
    output logic           cpu_irq_valid,
    output logic [DW-1:0]  cpu_irq_vector,
    output logic           xfer_req,
    output logic [CHW-1:0] xfer_chan,
    input  logic           xfer_ack,
    output logic [NCH-1:0] eot,
    output logic           clr_valid,
    output logic [DW-1:0]  clr_vector
);
    idd_state_e state, state_nx;
    logic [CHW-1:0]          cur_ch;
    logic [NCH-1:0][DW-1:0]  vecs;
    logic [NCH-1:0][CW-1:0]  cnts;
    logic [NCH-1:0]          vec_we, lo_we, hi_we, dec_v, exp_v;
    logic                    hit, expire;
    logic [CHW-1:0]          hit_ch;

    idd_vec_match #(.NCH(NCH), .DW(DW)) u_match (
        .vecs(vecs), .req_vec(irq_vector), .hit(hit), .chan(hit_ch)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign vec_we[g] = reg_we && (reg_addr == AW'(int'(VEC_BASE) + g));
        assign lo_we[g]  = reg_we && (reg_addr == AW'(int'(CNT_BASE) + 2 * g));
        assign hi_we[g]  = reg_we && (reg_addr == AW'(int'(CNT_BASE) + 2 * g + 1));
        assign dec_v[g]  = (state == S_XFER) && xfer_ack && (cur_ch == CHW'(g));
        assign exp_v[g]  = expire && (cur_ch == CHW'(g));

        idd_chan_regs #(.DW(DW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .vec_we(vec_we[g]), .cnt_lo_we(lo_we[g]), .cnt_hi_we(hi_we[g]),
            .wdata(reg_wdata), .dec(dec_v[g]), .expire(exp_v[g]),
            .vec(vecs[g]), .cnt(cnts[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cur_ch <= '0;
        else if (state == S_IDLE && irq_valid && hit) cur_ch <= hit_ch;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (irq_valid && hit) state_nx = S_XFER;
            S_XFER:  if (xfer_ack)         state_nx = S_CHECK;
            S_CHECK:                       state_nx = S_IDLE;
            default:                       state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_ready      = (state == S_IDLE);
        cpu_irq_valid  = (state == S_IDLE) && irq_valid && !hit;
        cpu_irq_vector = irq_vector;
        xfer_req       = (state == S_XFER);
        xfer_chan      = cur_ch;
        expire         = (state == S_CHECK) && (cnts[cur_ch] == '0);
        eot            = expire ? (NCH'(1) << cur_ch) : '0;
    end

    // Register read-back
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == AW'(int'(VEC_BASE) + i))         reg_rdata = vecs[i];
            if (reg_addr == AW'(int'(CNT_BASE) + 2 * i))     reg_rdata = cnts[i][DW-1:0];
            if (reg_addr == AW'(int'(CNT_BASE) + 2 * i + 1)) reg_rdata = cnts[i][CW-1:DW];
        end
    end

    // Write-only flag-clear register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_valid  <= 1'b0;
            clr_vector <= '0;
        end else begin
            clr_valid <= reg_we && (reg_addr == CLR_ADDR);
            if (reg_we && (reg_addr == CLR_ADDR)) clr_vector <= reg_wdata;
        end
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_chan));

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !irq_ready && !cpu_irq_valid);

    assert_eot_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eot));

    assert_eot_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eot != '0 |=> eot == '0);

    assert_hit_to_xfer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && irq_ready && !cpu_irq_valid |=> xfer_req);

    assert_zero_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && irq_ready && irq_vector == '0 |-> cpu_irq_valid);

    assert_clr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == CLR_ADDR |=> clr_valid && clr_vector == $past(reg_wdata));
endmodule

// File: tb/irq_dma_dispatch_test.sv
module irq_dma_dispatch_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_valid = 1'b0;
    logic [7:0] irq_vector = '0;
    logic       irq_ready, cpu_irq_valid;
    logic [7:0] cpu_irq_vector;
    logic       xfer_req;
    logic [2:0] xfer_chan;
    logic       xfer_ack = 1'b0;
    logic [7:0] eot;
    logic       clr_valid;
    logic [7:0] clr_vector;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_dma_dispatch uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_ready(irq_ready), .cpu_irq_valid(cpu_irq_valid),
        .cpu_irq_vector(cpu_irq_vector), .xfer_req(xfer_req), .xfer_chan(xfer_chan),
        .xfer_ack(xfer_ack), .eot(eot), .clr_valid(clr_valid), .clr_vector(clr_vector)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic arm(input int ch, input logic [7:0] v, input logic [15:0] n);
        wr(8'(ch), v);
        wr(8'(8'h10 + 2 * ch), n[7:0]);
        wr(8'(8'h11 + 2 * ch), n[15:8]);
    endtask

    // One request served by a channel, acknowledge delayed by one cycle.
    task automatic serve(input logic [7:0] v, input int ch, input bit last, input string req);
        logic [7:0] exp_eot;
        exp_eot = last ? (8'd1 << ch) : 8'd0;
        @(negedge clk);
        irq_valid = 1'b1; irq_vector = v;
        #1;
        chk(cpu_irq_valid == 1'b0, "R1", "matched request forwarded", 32'(cpu_irq_valid), 0);
        chk(irq_ready == 1'b1, "R10", "ready when idle", 32'(irq_ready), 1);
        @(negedge clk);
        irq_valid = 1'b0;
        #1;
        chk(xfer_req && xfer_chan == 3'(ch), req, "serving channel", 32'(xfer_chan), 32'(ch));
        chk(irq_ready == 1'b0, "R10", "ready while busy", 32'(irq_ready), 0);
        @(negedge clk);
        #1;
        chk(xfer_req && xfer_chan == 3'(ch), "R10", "request held until ack", 32'(xfer_req), 1);
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        #1;
        chk(eot == exp_eot, "R5", "end pulse after ack", 32'(eot), 32'(exp_eot));
        @(negedge clk);
        #1;
        chk(eot == 8'd0, "R5", "end pulse single cycle", 32'(eot), 0);
    endtask

    task automatic forwarded(input logic [7:0] v, input string req);
        @(negedge clk);
        irq_valid = 1'b1; irq_vector = v;
        #1;
        chk(cpu_irq_valid && cpu_irq_vector == v, req, "forwarded to cpu",
            32'(cpu_irq_vector), 32'(v));
        @(negedge clk);
        irq_valid = 1'b0;
        #1;
        chk(xfer_req == 1'b0, req, "no transfer for forwarded", 32'(xfer_req), 0);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk(!clr_valid && clr_vector == 0 && eot == 0 && !xfer_req && irq_ready,
            "R9", "idle outputs", {clr_valid, clr_vector, eot, xfer_req}, 0);
        for (int i = 0; i < 8; i++) begin
            rd(8'(i), d);
            chk(d == 0, "R9", "vector after reset", 32'(d), 0);
            rd(8'(8'h10 + 2 * i), d);
            chk(d == 0, "R9", "count low after reset", 32'(d), 0);
        end
    endtask

    task automatic t_forward;
        forwarded(8'h20, "R2");
        forwarded(8'h00, "R2");
    endtask

    task automatic t_shared;
        logic [7:0] d;
        arm(2, 8'h41, 16'd2);
        arm(5, 8'h41, 16'd1);
        serve(8'h41, 2, 1'b0, "R3");
        serve(8'h41, 2, 1'b1, "R3");
        rd(8'h02, d);
        chk(d == 0, "R6", "expired channel disarmed", 32'(d), 0);
        serve(8'h41, 5, 1'b1, "R6");
        forwarded(8'h41, "R6");
    endtask

    task automatic t_priority;
        arm(6, 8'h33, 16'd1);
        arm(1, 8'h33, 16'd1);
        arm(3, 8'h44, 16'd1);
        serve(8'h44, 3, 1'b1, "R1");
        serve(8'h33, 1, 1'b1, "R3");
        serve(8'h33, 6, 1'b1, "R6");
    endtask

    task automatic t_rearm;
        arm(4, 8'h55, 16'd3);
        arm(0, 8'h55, 16'd1);
        serve(8'h55, 0, 1'b1, "R7");
        arm(0, 8'h55, 16'd1);
        serve(8'h55, 0, 1'b1, "R7");
        serve(8'h55, 4, 1'b0, "R7");
        wr(8'h04, 8'h00);
    endtask

    task automatic t_counter;
        logic [7:0] d;
        arm(7, 8'h70, 16'h0103);
        rd(8'h07, d);
        chk(d == 8'h70, "R11", "vector read-back", 32'(d), 32'h70);
        serve(8'h70, 7, 1'b0, "R1");
        rd(8'h1E, d);
        chk(d == 8'h02, "R4", "count low after one ack", 32'(d), 32'h02);
        rd(8'h1F, d);
        chk(d == 8'h01, "R4", "count high after one ack", 32'(d), 32'h01);
        rd(8'h40, d);
        chk(d == 0, "R11", "unmapped read", 32'(d), 0);
        wr(8'h07, 8'h00);
    endtask

    task automatic t_clear;
        logic [7:0] d;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'hF8; reg_wdata = 8'h0A;
        #1;
        chk(clr_valid == 1'b0, "R8", "no clear before edge", 32'(clr_valid), 0);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        chk(clr_valid && clr_vector == 8'h0A, "R8", "clear command", 32'(clr_vector), 32'h0A);
        @(negedge clk);
        #1;
        chk(clr_valid == 1'b0, "R8", "clear is one pulse", 32'(clr_valid), 0);
        rd(8'hF8, d);
        chk(d == 0, "R8", "clear register reads zero", 32'(d), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_forward();
        t_shared();
        t_priority();
        t_rearm();
        t_counter();
        t_clear();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule